// File: doc/BRIEF.md
# GPIO Pin Interrupt Front End

This block turns the levels and transitions on 32 general-purpose input pins into one interrupt request for the processor. Each pin is first passed through a two-stage synchroniser. Per-pin settings then pick the event that counts on that pin: a level, a rising edge, a falling edge, or either edge. A second setting decides whether the event is latched in a status bit or only shown there while it lasts. Software reads and writes the settings as 16-bit registers on a simple memory-mapped bus. Pins 0 to 15 sit in a low register and pins 16 to 31 sit in a high register.

A status bit that is latched stays set until software writes a one to it. The block ANDs status with a per-pin enable and ORs the result of both halves into one interrupt line. It also gives the number of the winning pin so that the handler can branch without scanning the registers. A pin pending in the low half always wins over the high half. Within a half, the lowest bit wins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, with enable included, and `irq_o` is low. `irq_idx_o` is 0 whenever `irq_o` is low.
- R2: The byte address picks a register, and bit n of the low copy (or bit n−16 of the high copy) belongs to pin n. The address pairs (low, high) are: status 0x08/0x0A, enable 0x0C/0x0E, trigger type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling-edge select 0x20/0x22, rising-edge select 0x24/0x26. A configuration write is read back unchanged. Any other address reads zero and its writes are ignored.
- R3: A pin whose type bit is 0 is in level mode. It signals an event while its synchronised value equals its polarity bit (1 = active high, 0 = active low). A pin change before clock edge k shows in status after edge k+2.
- R4: A pin whose type bit is 1 is in edge mode. A rising edge counts when its rising-select bit is 1, and a falling edge counts when its falling-select bit is 1. With both bits set, both edges count. With neither set, no event occurs. Polarity has no effect in this mode.
- R5: With the hold bit at 1, an event sets the status bit and the bit stays set until it is cleared.
- R6: With the hold bit at 0, the status bit is the event of the previous cycle: a one-cycle pulse for an edge, and a copy of the active state for a level. A write to status does not keep it low past the next cycle.
- R7: Writing 1 to a status bit clears a held bit, and writing 0 leaves it unchanged. A status write changes no configuration register.
- R8: If an event and a clear of the same held bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some pin is both pending and enabled. A pending pin whose enable is 0 has no effect on `irq_o` or `irq_idx_o`.
- R10: `irq_idx_o` gives the lowest pending-and-enabled pin of the low half. The high half is used only when the low half has none, and then its lowest such pin wins (index = pin number).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Cascaded interrupt request, also valid flag for the index |
| irq_idx_o | output | 5 | Number of the winning pending pin |

## Verification
The case that needs care is a write-one clear of a held status bit that lands in the same cycle as a new event on that pin. The set must win there, while a clear one cycle earlier or later must leave the bit cleared or set again. The bench provokes this by toggling an edge-mode pin and then issuing the clear after a delay that it sweeps across the synchroniser latency. It also holds an active level while clearing. A behavioural model decides, cycle by cycle, which outcome is correct, and the bench compares the status read-back and the interrupt outputs against it on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 6;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_STAT,
        FLD_EN,
        FLD_TYPE,
        FLD_POL,
        FLD_HOLD,
        FLD_FALL,
        FLD_RISE
    } fld_e;

    typedef struct packed {
        fld_e fld;
        logic hi;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.hi = a[1];
        case (a)
            6'h08, 6'h0A: d.fld = FLD_STAT;
            6'h0C, 6'h0E: d.fld = FLD_EN;
            6'h10, 6'h12: d.fld = FLD_TYPE;
            6'h14, 6'h16: d.fld = FLD_POL;
            6'h18, 6'h1A: d.fld = FLD_HOLD;
            6'h20, 6'h22: d.fld = FLD_FALL;
            6'h24, 6'h26: d.fld = FLD_RISE;
            default:      d.fld = FLD_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] lvl_o,
    output logic [PINS-1:0] rise_o,
    output logic [PINS-1:0] fall_o
);

    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int PINS   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   stat_i,
    output logic [PINS-1:0]   en_o,
    output logic [PINS-1:0]   typ_o,
    output logic [PINS-1:0]   pol_o,
    output logic [PINS-1:0]   hold_o,
    output logic [PINS-1:0]   fall_en_o,
    output logic [PINS-1:0]   rise_en_o,
    output logic [PINS-1:0]   clr_o
);

    decode_t dec;
    assign dec = decode_addr(bus_addr);

    function automatic logic [PINS-1:0] put_half(input logic [PINS-1:0] old,
                                                 input logic hi,
                                                 input logic [DATA_W-1:0] d);
        logic [PINS-1:0] v;
        v = old;
        if (hi) v[PINS-1:DATA_W] = d;
        else    v[DATA_W-1:0]    = d;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] get_half(input logic [PINS-1:0] v,
                                                   input logic hi);
        return hi ? v[PINS-1:DATA_W] : v[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o      <= '0;
            typ_o     <= '0;
            pol_o     <= '0;
            hold_o    <= '0;
            fall_en_o <= '0;
            rise_en_o <= '0;
        end else if (bus_wr) begin
            unique case (dec.fld)
                FLD_EN:   en_o      <= put_half(en_o,      dec.hi, bus_wdata);
                FLD_TYPE: typ_o     <= put_half(typ_o,     dec.hi, bus_wdata);
                FLD_POL:  pol_o     <= put_half(pol_o,     dec.hi, bus_wdata);
                FLD_HOLD: hold_o    <= put_half(hold_o,    dec.hi, bus_wdata);
                FLD_FALL: fall_en_o <= put_half(fall_en_o, dec.hi, bus_wdata);
                FLD_RISE: rise_en_o <= put_half(rise_en_o, dec.hi, bus_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_o = '0;
        if (bus_wr && dec.fld == FLD_STAT)
            clr_o = put_half('0, dec.hi, bus_wdata);
    end

    always_comb begin
        unique case (dec.fld)
            FLD_STAT: bus_rdata = get_half(stat_i,    dec.hi);
            FLD_EN:   bus_rdata = get_half(en_o,      dec.hi);
            FLD_TYPE: bus_rdata = get_half(typ_o,     dec.hi);
            FLD_POL:  bus_rdata = get_half(pol_o,     dec.hi);
            FLD_HOLD: bus_rdata = get_half(hold_o,    dec.hi);
            FLD_FALL: bus_rdata = get_half(fall_en_o, dec.hi);
            FLD_RISE: bus_rdata = get_half(rise_en_o, dec.hi);
            default:  bus_rdata = '0;
        endcase
    end

    // R1: enables come out of reset cleared
    assert_en_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_o == '0));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] lvl_i,
    input  logic [PINS-1:0] rise_i,
    input  logic [PINS-1:0] fall_i,
    input  logic [PINS-1:0] typ_i,
    input  logic [PINS-1:0] pol_i,
    input  logic [PINS-1:0] hold_i,
    input  logic [PINS-1:0] fall_en_i,
    input  logic [PINS-1:0] rise_en_i,
    input  logic [PINS-1:0] clr_i,
    output logic [PINS-1:0] stat_o
);

    logic [PINS-1:0] ev;
    logic [PINS-1:0] st_d;

    always_comb begin
        ev   = (typ_i & ((rise_i & rise_en_i) | (fall_i & fall_en_i)))
             | (~typ_i & ~(lvl_i ^ pol_i));
        // set wins over a clear in the same cycle
        st_d = (hold_i & ((stat_o & ~clr_i) | ev)) | (~hold_i & ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= st_d;
    end

    // R5: a held bit with no clear stays set
    assert_hold_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o & hold_i & ~clr_i) != '0) |=>
        ((stat_o & $past(stat_o & hold_i & ~clr_i)) == $past(stat_o & hold_i & ~clr_i)));

    // R7: a clear with no new event empties the held bit
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & hold_i & ~ev) != '0) |=>
        ((stat_o & $past(clr_i & hold_i & ~ev)) == '0));

    // R8: an event in the clear cycle keeps the bit set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ev) != '0) |=>
        ((stat_o & $past(clr_i & ev)) == $past(clr_i & ev)));

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
    parameter int DATA_W = 16,
    parameter int PINS   = 2 * DATA_W,
    parameter int IDX_W  = $clog2(PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int NH         = PINS / DATA_W;
    localparam int HALF_IDX_W = $clog2(DATA_W);

    logic [NH-1:0]                 any_v;
    logic [NH-1:0][HALF_IDX_W-1:0] idx_v;

    for (genvar h = 0; h < NH; h++) begin : g_half
        logic                  any_h;
        logic [HALF_IDX_W-1:0] idx_h;
        always_comb begin
            any_h = 1'b0;
            idx_h = '0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
                if (pend_i[h*DATA_W + i]) begin
                    any_h = 1'b1;
                    idx_h = HALF_IDX_W'(i);
                end
            end
        end
        assign any_v[h] = any_h;
        assign idx_v[h] = idx_h;
    end

    // lower half is scanned last so it overrides the upper halves
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int h = NH - 1; h >= 0; h--) begin
            if (any_v[h]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(h * DATA_W + int'(idx_v[h]));
            end
        end
    end

    // R10: winner is pending and nothing below it is
    assert_idx_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[idx_o]);
    assert_idx_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((pend_i & ((PINS'(1) << idx_o) - PINS'(1))) == '0));
    // R1: index parks at zero when idle
    assert_idx_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (idx_o == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int PINS   = 2 * DATA_W,
    parameter int IDX_W  = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic [IDX_W-1:0]  irq_idx_o
);

    logic [PINS-1:0] lvl, rise, fall;
    logic [PINS-1:0] en, typ, pol, hold, fall_en, rise_en, clr;
    logic [PINS-1:0] stat;
    logic [PINS-1:0] pend;

    gpio_irq_sync #(.PINS(PINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_irq_regs #(.DATA_W(DATA_W), .PINS(PINS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_i    (stat),
        .en_o      (en),
        .typ_o     (typ),
        .pol_o     (pol),
        .hold_o    (hold),
        .fall_en_o (fall_en),
        .rise_en_o (rise_en),
        .clr_o     (clr)
    );

    gpio_irq_status #(.PINS(PINS)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .rise_i    (rise),
        .fall_i    (fall),
        .typ_i     (typ),
        .pol_i     (pol),
        .hold_i    (hold),
        .fall_en_i (fall_en),
        .rise_en_i (rise_en),
        .clr_i     (clr),
        .stat_o    (stat)
    );

    assign pend = stat & en;

    gpio_irq_prio #(.DATA_W(DATA_W), .PINS(PINS), .IDX_W(IDX_W)) i_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .valid_o (irq_o),
        .idx_o   (irq_idx_o)
    );

    // R9: a masked pin never raises the line on its own
    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en) == '0) |-> !irq_o);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [4:0]  idx;

    always #2 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .irq_idx_o(idx)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_s1[32], m_s2[32], m_s3[32], m_st[32];
    bit m_en[32], m_ty[32], m_pl[32], m_ho[32], m_fe[32], m_re[32];

    function automatic int base_of(input logic [5:0] a);
        return a[1] ? 16 : 0;
    endfunction

    function automatic logic [15:0] pack(ref bit v[32], input int b);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[b + i];
        return r;
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        int b = base_of(a);
        case (a)
            6'h08, 6'h0A: return pack(m_st, b);
            6'h0C, 6'h0E: return pack(m_en, b);
            6'h10, 6'h12: return pack(m_ty, b);
            6'h14, 6'h16: return pack(m_pl, b);
            6'h18, 6'h1A: return pack(m_ho, b);
            6'h20, 6'h22: return pack(m_fe, b);
            6'h24, 6'h26: return pack(m_re, b);
            default:      return 16'h0;
        endcase
    endfunction

    task automatic m_reset();
        for (int p = 0; p < 32; p++) begin
            m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0; m_st[p] = 0;
            m_en[p] = 0; m_ty[p] = 0; m_pl[p] = 0; m_ho[p] = 0; m_fe[p] = 0; m_re[p] = 0;
        end
    endtask

    task automatic m_step();
        bit nst[32];
        int b = base_of(addr);
        for (int p = 0; p < 32; p++) begin
            bit r = m_s2[p] && !m_s3[p];
            bit f = !m_s2[p] && m_s3[p];
            bit ev = m_ty[p] ? ((r && m_re[p]) || (f && m_fe[p])) : (m_s2[p] == m_pl[p]);
            bit c = wr && (addr == 6'h08 || addr == 6'h0A) && (p >= b) && (p < b + 16)
                    && wdata[p - b];
            nst[p] = m_ho[p] ? (ev || (m_st[p] && !c)) : ev;
        end
        if (wr) begin
            for (int i = 0; i < 16; i++) begin
                case (addr)
                    6'h0C, 6'h0E: m_en[b + i] = wdata[i];
                    6'h10, 6'h12: m_ty[b + i] = wdata[i];
                    6'h14, 6'h16: m_pl[b + i] = wdata[i];
                    6'h18, 6'h1A: m_ho[b + i] = wdata[i];
                    6'h20, 6'h22: m_fe[b + i] = wdata[i];
                    6'h24, 6'h26: m_re[b + i] = wdata[i];
                    default: ;
                endcase
            end
        end
        for (int p = 0; p < 32; p++) begin
            m_s3[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pins[p]; m_st[p] = nst[p];
        end
    endtask

    task automatic compare();
        bit   e_irq = 0;
        logic [4:0] e_idx = 0;
        logic [15:0] e_rd = m_read(addr);
        for (int p = 31; p >= 0; p--) if (m_st[p] && m_en[p]) begin e_irq = 1; e_idx = 5'(p); end
        compared++;
        if (irq !== e_irq) begin
            mismatched++;
            $display("FAIL %s: irq_o actual %0b expected %0b", cur_req, irq, e_irq);
        end
        if (idx !== e_idx) begin
            mismatched++;
            $display("FAIL %s: irq_idx_o actual %0d expected %0d", cur_req, idx, e_idx);
        end
        if (rdata !== e_rd) begin
            mismatched++;
            $display("FAIL %s: rdata@%h actual %h expected %h", cur_req, addr, rdata, e_rd);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr16(input logic [5:0] a, input logic [15:0] d);
        wr = 1; addr = a; wdata = d;
        cyc();
        wr = 0; wdata = 0;
    endtask

    task automatic rd(input logic [5:0] a);
        addr = a;
        cyc();
    endtask

    task automatic cfg_all(input logic [15:0] t, input logic [15:0] pl, input logic [15:0] h,
                           input logic [15:0] fe, input logic [15:0] re);
        wr16(6'h10, t);  wr16(6'h12, t);
        wr16(6'h14, pl); wr16(6'h16, pl);
        wr16(6'h18, h);  wr16(6'h1A, h);
        wr16(6'h20, fe); wr16(6'h22, fe);
        wr16(6'h24, re); wr16(6'h26, re);
    endtask

    localparam logic [5:0] MAPPED [14] = '{6'h08, 6'h0A, 6'h0C, 6'h0E, 6'h10, 6'h12,
        6'h14, 6'h16, 6'h18, 6'h1A, 6'h20, 6'h22, 6'h24, 6'h26};

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: everything zero out of reset
        cur_req = "R1";
        compare();
        foreach (MAPPED[i]) rd(MAPPED[i]);

        // R2: read-back of configuration, unmapped addresses
        cur_req = "R2";
        for (int i = 2; i < 14; i++) wr16(MAPPED[i], 16'hA5C3 ^ 16'(i * 16'h1111));
        foreach (MAPPED[i]) rd(MAPPED[i]);
        wr16(6'h30, 16'hFFFF); rd(6'h30); rd(6'h09); rd(6'h1C);
        wr16(6'h0C, 0); wr16(6'h0E, 0);
        cfg_all(0, 16'hFFFF, 0, 0, 0);
        wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);
        idle(3);

        // R3: level mode, mixed polarity
        cur_req = "R3";
        cfg_all(16'h0000, 16'h00FF, 16'h0000, 16'h0000, 16'h0000);
        wr16(6'h0C, 16'hFFFF); wr16(6'h0E, 16'hFFFF);
        addr = 6'h08;
        pins = 32'h0000_0000; idle(4);
        pins = 32'h00FF_00FF; idle(4); rd(6'h0A);
        pins = 32'hFF00_FF00; idle(4); rd(6'h08);
        pins = 32'h0000_FFFF; cyc(); cyc(); cyc(); cyc();

        // R4: edge selection with latching
        cur_req = "R4";
        pins = 0;
        cfg_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0F0F, 16'h00FF);
        idle(4);
        wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);
        addr = 6'h08;
        pins = 32'hFFFF_FFFF; idle(4); rd(6'h0A);
        wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);
        pins = 32'h0000_0000; idle(4); rd(6'h0A); rd(6'h08);

        // R5 / R7: held bits and write-one-to-clear
        cur_req = "R7";
        wr16(6'h08, 16'h0000); rd(6'h08);
        wr16(6'h0A, 16'h0000); rd(6'h0A);
        wr16(6'h08, 16'h0101); rd(6'h08); rd(6'h10);
        cur_req = "R5";
        idle(6);
        wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);

        // R6: pass-through, edge pulses and level copy
        cur_req = "R6";
        wr16(6'h18, 0); wr16(6'h1A, 0);
        addr = 6'h08;
        pins = 32'h00FF_00FF; idle(5);
        pins = 32'h0000_0000; idle(5);
        wr16(6'h10, 0); wr16(6'h14, 16'h000F);
        pins = 32'h0000_0003; idle(2);
        wr16(6'h08, 16'hFFFF); idle(3);
        pins = 0; idle(3);

        // R8: clear against a new event, swept delay
        cur_req = "R8";
        cfg_all(16'hFFFF, 0, 16'hFFFF, 0, 16'hFFFF);
        wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);
        for (int d = 0; d < 5; d++) begin
            pins[3] = 1; pins[20] = 1;
            idle(d);
            wr16(6'h08, 16'h0008);
            wr16(6'h0A, 16'h0010);
            addr = 6'h08; idle(3);
            pins[3] = 0; pins[20] = 0; idle(2);
            wr16(6'h08, 16'hFFFF); wr16(6'h0A, 16'hFFFF);
        end
        wr16(6'h10, 16'hFFF7); pins[3] = 1; idle(4);
        wr16(6'h08, 16'h0008); wr16(6'h08, 16'h0008); rd(6'h08);
        pins[3] = 0; idle(4); wr16(6'h08, 16'h0008); rd(6'h08);
        wr16(6'h10, 16'hFFFF);

        // R9: enable masking
        cur_req = "R9";
        cfg_all(16'hFFFF, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        pins = 32'h8421_8421; idle(4);
        wr16(6'h0C, 0); wr16(6'h0E, 0); idle(2);
        wr16(6'h0E, 16'h8000); idle(2);
        wr16(6'h0C, 16'h0020); idle(2);
        wr16(6'h0C, 16'h0001); idle(2);

        // R10: low half first, then high half
        cur_req = "R10";
        wr16(6'h0C, 16'hFFFF); wr16(6'h0E, 16'hFFFF);
        addr = 6'h08; idle(2);
        wr16(6'h08, 16'h0001); wr16(6'h08, 16'h0020); wr16(6'h08, 16'h0400);
        wr16(6'h08, 16'h8000); wr16(6'h0A, 16'h0001); wr16(6'h0A, 16'h0020);
        wr16(6'h0A, 16'h0400); wr16(6'h0A, 16'h8000);

        // mixed random traffic
        cur_req = "R5";
        for (int n = 0; n < 600; n++) begin
            pins = pins ^ ($urandom_range(0, 3) == 0 ? $urandom() : 32'h0);
            if ($urandom_range(0, 3) == 0)
                wr16(MAPPED[$urandom_range(0, 13)], 16'($urandom()));
            else
                rd(MAPPED[$urandom_range(0, 13)]);
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule